// File: doc/BRIEF.md
# I/O Port Breakpoint Matcher

This block decides whether an I/O port access hits a debug breakpoint. Each access has a 16-bit port number and a width of 1, 2 or 4 bytes, and it covers the ports from `port` to `port + width - 1`. The block checks that range against two sets of four address slots. The first set is owned by the host debugger. The second set belongs to the guest and is described by a packed debug-control word. Host slots always win over guest slots. Within each set, the lowest-numbered matching slot is chosen.

A one-cycle `start` strobe samples the access and all slot inputs. On the next cycle `valid` goes high for one cycle. At that point `result` gives the outcome: none, host hit (with a slot index and a request to clear single-stepping) or guest trap. `sts_out` and `ctl_out` carry the status and control words that software should write back. A small two-state machine (IDLE, REPORT) holds the result. It has these transitions:
- IDLE to REPORT on `start`.
- REPORT to REPORT on a new `start`.
- REPORT to IDLE when `start` is absent.

Top module: `iobp_matcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid` is 0, `result` is 0 and `clear_step` is 0.
- R2: A `start` in cycle n gives `valid`=1 in cycle n+1 only. With `valid`=0, `result`, `host_slot`, `clear_step`, `sts_out` and `ctl_out` are all 0. Result codes are 0 for none, 1 for host and 2 for guest.
- R3: A host slot takes part only when three conditions hold: `host_en` is 1, `host_is_reg` is 1, and its 2-bit `host_rw` field equals 2'b10.
- R4: A host slot with length 2^`host_len_log` covers the range from `addr & ~(len-1)` to that value plus `len-1`. It matches when that range overlaps the access range at one or more ports.
- R5: A host match has priority over any guest match. It gives result 1, the slot index on `host_slot` and `clear_step`=1, and it passes the status and control words through unchanged.
- R6: Guest slots are considered only when all three of these hold: some bit of `guest_ctl[7:0]` is set, some RW field `guest_ctl[17+4i:16+4i]` equals 2'b10, and `dbg_ext_en` is 1.
- R7: Guest slot i takes part when its local enable (bit 2i) or its global enable (bit 2i+1) is set and its RW field equals 2'b10.
- R8: The guest length field `guest_ctl[19+4i:18+4i]` selects a mask: code 0 gives 0, code 1 gives 1, code 2 gives 7 and code 3 gives 3. The slot covers the range from `addr & ~mask` to that value plus `mask`.
- R9: Within each set, the lowest-indexed matching slot wins.
- R10: A guest hit on slot k gives result 2. It also produces two updated words:
  - `sts_out` is the input status word with bits [3:0] replaced by a one-hot value that has bit k set.
  - `ctl_out` is the input control word with bit 13 cleared.
- R11: With no match, the result is 0, `clear_step` is 0, and both words pass through unchanged.
- R12: The access range is computed one bit wider than the address. Because of this, an access at 0xFFFF of width 4 reaches 0x10002 and never wraps to port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample the access and the slots this cycle |
| port | input | 16 | First port of the access |
| width | input | 3 | Access width in bytes (1, 2 or 4) |
| host_addr | input | NSLOT*ADDR_W | Host slot addresses, slot i at [i*ADDR_W +: ADDR_W] |
| host_len_log | input | NSLOT*2 | Host slot log2 length |
| host_en | input | NSLOT | Host slot enables |
| host_is_reg | input | NSLOT | Host slot is of register kind |
| host_rw | input | NSLOT*2 | Host slot type field |
| guest_addr | input | NSLOT*ADDR_W | Guest slot addresses |
| guest_ctl | input | 32 | Guest debug-control word |
| guest_sts | input | 32 | Guest debug-status word |
| dbg_ext_en | input | 1 | Debug-extensions enable |
| valid | output | 1 | Result valid (one cycle after start) |
| result | output | 2 | 0 none, 1 host, 2 guest |
| host_slot | output | 2 | Index of the matching host slot |
| clear_step | output | 1 | Request to clear single-stepping |
| sts_out | output | 32 | Status word to write back |
| ctl_out | output | 32 | Control word to write back |

## Verification
The assertions are checked on every cycle:
- The one-cycle timing of `valid` after `start`.
- The quiet zero outputs while `valid` is low.
- That `clear_step` goes with host results only.
- The one-hot status hit field and the cleared bit 13 on every guest trap.
- That no guest trap occurs while debug extensions are off.

Only the bench scenarios can show which slot is chosen:
- Alignment under each length code.
- Exact overlap at range edges.
- Priority of host over guest.
- First-match order.
- Behaviour at the top of the port space.

// File: rtl/iobp_pkg.sv
package iobp_pkg;
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HOST  = 2'd1,
        RES_GUEST = 2'd2
    } res_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } st_e;

    localparam logic [1:0] RW_IO  = 2'b10;
    localparam int         GD_BIT = 13;
    localparam int         HIT_W  = 4;

    // Inverse alignment mask for a guest length code.
    function automatic logic [2:0] len_mask(input logic [1:0] code);
        case (code)
            2'd0:    len_mask = 3'd0;
            2'd1:    len_mask = 3'd1;
            2'd2:    len_mask = 3'd7;
            default: len_mask = 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/iobp_host_slot.sv
module iobp_host_slot #(
    parameter int ADDR_W = 32,
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len_log,
    input  logic              en,
    input  logic              is_reg,
    input  logic [1:0]        rw,
    input  logic [EXT_W-1:0]  first,
    input  logic [EXT_W-1:0]  last,
    output logic              hit
);
    import iobp_pkg::*;

    logic [EXT_W-1:0] len, lo, hi;

    always_comb begin
        len = EXT_W'(1) << len_log;
        lo  = {1'b0, addr} & ~(len - EXT_W'(1));
        hi  = lo + len - EXT_W'(1);
        hit = en && is_reg && (rw == RW_IO) && (lo <= last) && (hi >= first);
    end
endmodule

// File: rtl/iobp_guest_slot.sv
module iobp_guest_slot #(
    parameter int ADDR_W = 32,
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [1:0]        rw,
    input  logic [1:0]        len_code,
    input  logic [EXT_W-1:0]  first,
    input  logic [EXT_W-1:0]  last,
    output logic              hit
);
    import iobp_pkg::*;

    logic [EXT_W-1:0] mask, lo, hi;

    always_comb begin
        mask = EXT_W'(len_mask(len_code));
        lo   = {1'b0, addr} & ~mask;
        hi   = lo + mask;
        hit  = en && (rw == RW_IO) && (lo <= last) && (hi >= first);
    end
endmodule

// File: rtl/iobp_first.sv
module iobp_first #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/iobp_matcher.sv
module iobp_matcher #(
    parameter int NSLOT  = 4,
    parameter int ADDR_W = 32,
    localparam int EXT_W = ADDR_W + 1,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [15:0]             port,
    input  logic [2:0]              width,
    input  logic [NSLOT*ADDR_W-1:0] host_addr,
    input  logic [NSLOT*2-1:0]      host_len_log,
    input  logic [NSLOT-1:0]        host_en,
    input  logic [NSLOT-1:0]        host_is_reg,
    input  logic [NSLOT*2-1:0]      host_rw,
    input  logic [NSLOT*ADDR_W-1:0] guest_addr,
    input  logic [31:0]             guest_ctl,
    input  logic [31:0]             guest_sts,
    input  logic                    dbg_ext_en,
    output logic                    valid,
    output logic [1:0]              result,
    output logic [IDX_W-1:0]        host_slot,
    output logic                    clear_step,
    output logic [31:0]             sts_out,
    output logic [31:0]             ctl_out
);
    import iobp_pkg::*;

    logic [EXT_W-1:0] acc_first, acc_last;
    logic [NSLOT-1:0] host_hit, guest_hit, guest_io;
    logic             host_any, guest_any, guest_gate;
    logic [IDX_W-1:0] host_idx, guest_idx;

    assign acc_first = EXT_W'(port);
    assign acc_last  = acc_first + EXT_W'(width) - EXT_W'(1);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        iobp_host_slot #(.ADDR_W(ADDR_W)) u_host (
            .addr    (host_addr[i*ADDR_W +: ADDR_W]),
            .len_log (host_len_log[2*i +: 2]),
            .en      (host_en[i]),
            .is_reg  (host_is_reg[i]),
            .rw      (host_rw[2*i +: 2]),
            .first   (acc_first),
            .last    (acc_last),
            .hit     (host_hit[i])
        );
        assign guest_io[i] = (guest_ctl[16 + 4*i +: 2] == RW_IO);
        iobp_guest_slot #(.ADDR_W(ADDR_W)) u_guest (
            .addr     (guest_addr[i*ADDR_W +: ADDR_W]),
            .en       (guest_ctl[2*i] | guest_ctl[2*i + 1]),
            .rw       (guest_ctl[16 + 4*i +: 2]),
            .len_code (guest_ctl[18 + 4*i +: 2]),
            .first    (acc_first),
            .last     (acc_last),
            .hit      (guest_hit[i])
        );
    end

    assign guest_gate = (|guest_ctl[2*NSLOT-1:0]) && (|guest_io) && dbg_ext_en;

    iobp_first #(.N(NSLOT)) u_host_pick (
        .hits (host_hit), .any (host_any), .idx (host_idx)
    );
    iobp_first #(.N(NSLOT)) u_guest_pick (
        .hits (guest_hit), .any (guest_any), .idx (guest_idx)
    );

    // Decision for the access currently on the inputs
    res_e             res_n;
    logic [31:0]      sts_n, ctl_n;
    always_comb begin
        res_n = RES_NONE;
        sts_n = guest_sts;
        ctl_n = guest_ctl;
        if (host_any) begin
            res_n = RES_HOST;
        end else if (guest_gate && guest_any) begin
            res_n = RES_GUEST;
            sts_n = {guest_sts[31:HIT_W], HIT_W'(1) << guest_idx};
            ctl_n[GD_BIT] = 1'b0;
        end
    end

    // State register
    st_e              state, state_n;
    res_e             r_res;
    logic [IDX_W-1:0] r_idx;
    logic [31:0]      r_sts, r_ctl;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   state_n = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_n = start ? ST_REPORT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            r_res <= RES_NONE;
            r_idx <= '0;
            r_sts <= '0;
            r_ctl <= '0;
        end else begin
            state <= state_n;
            if (start) begin
                r_res <= res_n;
                r_idx <= host_idx;
                r_sts <= sts_n;
                r_ctl <= ctl_n;
            end
        end
    end

    // Outputs
    always_comb begin
        valid      = (state == ST_REPORT);
        result     = valid ? r_res : RES_NONE;
        clear_step = valid && (r_res == RES_HOST);
        host_slot  = (valid && r_res == RES_HOST) ? r_idx : '0;
        sts_out    = valid ? r_sts : '0;
        ctl_out    = valid ? r_ctl : '0;
    end

    AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid); // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (result == 2'd0 && !clear_step && sts_out == '0 && ctl_out == '0)); // R2
    AST_STEP_ONLY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        clear_step |-> (valid && result == 2'd1)); // R5
    AST_GUEST_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && result == 2'd2) |-> ($onehot(sts_out[3:0]) && !ctl_out[GD_BIT])); // R10
    AST_GATE_DE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dbg_ext_en && !host_any) |=> (result != 2'd2)); // R6
endmodule

// File: tb/sim_iobp_matcher.sv
module sim_iobp_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int AW = 32;

    logic          clk = 0, rst_n = 0, start = 0;
    logic [15:0]   port = 0;
    logic [2:0]    width = 1;
    logic [NS*AW-1:0] host_addr = 0, guest_addr = 0;
    logic [NS*2-1:0]  host_len_log = 0, host_rw = 0;
    logic [NS-1:0]    host_en = 0, host_is_reg = 0;
    logic [31:0]   guest_ctl = 0, guest_sts = 0;
    logic          dbg_ext_en = 1;
    logic          valid, clear_step;
    logic [1:0]    result, host_slot;
    logic [31:0]   sts_out, ctl_out;

    iobp_matcher #(.NSLOT(NS), .ADDR_W(AW)) u0 (
        .clk, .rst_n, .start, .port, .width, .host_addr, .host_len_log,
        .host_en, .host_is_reg, .host_rw, .guest_addr, .guest_ctl,
        .guest_sts, .dbg_ext_en, .valid, .result, .host_slot, .clear_step,
        .sts_out, .ctl_out
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [1:0]  res;
        logic [1:0]  idx;
        logic        step;
        logic [31:0] sts;
        logic [31:0] ctl;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0;
    bit   done = 0;

    // Monitor: pops one expectation per valid cycle
    always @(negedge clk) begin
        if (rst_n && valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2: unexpected valid, actual result=%0d expected no result", result);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (result !== e.res || host_slot !== e.idx || clear_step !== e.step ||
                    sts_out !== e.sts || ctl_out !== e.ctl) begin
                    bad++;
                    $display("FAIL %s: actual res=%0d slot=%0d step=%0b sts=%h ctl=%h expected res=%0d slot=%0d step=%0b sts=%h ctl=%h",
                             e.tag, result, host_slot, clear_step, sts_out, ctl_out,
                             e.res, e.idx, e.step, e.sts, e.ctl);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: pulse start, push expectation, confirm valid drops after one cycle
    task automatic send(input logic [15:0] p, input logic [2:0] w, input logic [1:0] res,
                        input logic [1:0] idx, input logic [31:0] sts_e,
                        input logic [31:0] ctl_e, input string tag);
        exp_t e;
        @(negedge clk);
        port = p; width = w; start = 1;
        e.res = res; e.idx = idx; e.step = (res == 2'd1); e.sts = sts_e; e.ctl = ctl_e; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk(valid === 1'b0, "R2 valid one cycle", {31'd0, valid}, 32'd0);
    endtask

    function automatic logic [31:0] gctl(input int slot, input bit l, input bit g,
                                         input logic [1:0] rw, input logic [1:0] len);
        logic [31:0] c = 0;
        c[2*slot] = l; c[2*slot+1] = g;
        c[16+4*slot +: 2] = rw; c[18+4*slot +: 2] = len;
        return c;
    endfunction

    task automatic host_set(input int s, input logic [31:0] a, input logic [1:0] ll,
                            input bit en, input bit isr, input logic [1:0] rw);
        host_addr[s*AW +: AW] = a; host_len_log[2*s +: 2] = ll;
        host_en[s] = en; host_is_reg[s] = isr; host_rw[2*s +: 2] = rw;
    endtask

    task automatic clear_all();
        host_addr = 0; host_len_log = 0; host_en = 0; host_is_reg = 0; host_rw = 0;
        guest_addr = 0; guest_ctl = 0; dbg_ext_en = 1;
    endtask

    function automatic logic [31:0] hitsts(input logic [31:0] s, input int k);
        return (s & ~32'hF) | (32'h1 << k);
    endfunction

    localparam logic [31:0] STS0 = 32'h0000_C00A;

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        guest_sts = STS0;
        repeat (3) @(negedge clk);
        chk(valid === 0 && result === 0 && clear_step === 0, "R1 reset state", {30'd0, result}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(valid === 0 && result === 0, "R1 after release", {30'd0, result}, 0);

        // R11: nothing armed, words pass through
        guest_ctl = 32'h0000_2000;
        send(16'h0060, 1, 0, 0, STS0, 32'h0000_2000, "R11 no hit");

        // R3/R4: host slot 2 at 0x82 len 4 -> 0x80..0x83
        clear_all();
        host_set(2, 32'h82, 2, 1, 1, 2'b10);
        send(16'h0080, 1, 1, 2, STS0, 0, "R4 host aligned hit");
        send(16'h0084, 1, 0, 0, STS0, 0, "R4 host past end");
        send(16'h007E, 2, 0, 0, STS0, 0, "R4 host below start");
        send(16'h007F, 2, 1, 2, STS0, 0, "R4 host overlap edge");
        host_set(2, 32'h82, 2, 1, 0, 2'b10);
        send(16'h0080, 1, 0, 0, STS0, 0, "R3 host not register kind");
        host_set(2, 32'h82, 2, 1, 1, 2'b01);
        send(16'h0080, 1, 0, 0, STS0, 0, "R3 host wrong type");
        host_set(2, 32'h82, 2, 0, 1, 2'b10);
        send(16'h0080, 1, 0, 0, STS0, 0, "R3 host disabled");

        // R5: host slot 3 and guest slot 0 both match
        clear_all();
        host_set(3, 32'h3F8, 0, 1, 1, 2'b10);
        guest_addr[0 +: AW] = 32'h3F8;
        guest_ctl = gctl(0, 1, 0, 2'b10, 0) | 32'h2000;
        send(16'h03F8, 1, 1, 3, STS0, guest_ctl, "R5 host before guest");

        // R9: host slots 1 and 3 both match
        host_set(1, 32'h3F8, 3, 1, 1, 2'b10);
        send(16'h03F8, 1, 1, 1, STS0, guest_ctl, "R9 host first match");

        // R10: guest slot 1 hit with status and control write-back
        clear_all();
        guest_addr[1*AW +: AW] = 32'h3F8;
        guest_ctl = gctl(1, 1, 0, 2'b10, 0) | 32'h2000;
        send(16'h03F8, 1, 2, 0, hitsts(STS0, 1), gctl(1, 1, 0, 2'b10, 0), "R10 guest write-back");

        // R8: length codes
        guest_addr[1*AW +: AW] = 32'h105;
        guest_ctl = gctl(1, 1, 0, 2'b10, 2);
        send(16'h0107, 1, 2, 0, hitsts(STS0, 1), guest_ctl, "R8 code2 mask7 hit");
        send(16'h0108, 1, 0, 0, STS0, guest_ctl, "R8 code2 mask7 miss");
        guest_ctl = gctl(1, 1, 0, 2'b10, 3);
        send(16'h0103, 1, 0, 0, STS0, guest_ctl, "R8 code3 mask3 miss");
        send(16'h0103, 2, 2, 0, hitsts(STS0, 1), guest_ctl, "R8 code3 mask3 hit");
        guest_ctl = gctl(1, 1, 0, 2'b10, 1);
        send(16'h0106, 1, 0, 0, STS0, guest_ctl, "R8 code1 mask1 miss");
        send(16'h0104, 1, 2, 0, hitsts(STS0, 1), guest_ctl, "R8 code1 mask1 hit");

        // R6: debug extensions off blocks the guest
        clear_all();
        guest_addr[0 +: AW] = 32'h70;
        guest_ctl = gctl(0, 0, 1, 2'b10, 0);
        dbg_ext_en = 0;
        send(16'h0070, 1, 0, 0, STS0, guest_ctl, "R6 extensions off");
        dbg_ext_en = 1;
        send(16'h0070, 1, 2, 0, hitsts(STS0, 0), guest_ctl, "R6 extensions on");

        // R7: global enable alone, and a wrong type with an enable
        clear_all();
        guest_addr[2*AW +: AW] = 32'h40;
        guest_addr[3*AW +: AW] = 32'h900;
        guest_ctl = gctl(2, 0, 1, 2'b10, 0);
        send(16'h0040, 1, 2, 0, hitsts(STS0, 2), guest_ctl, "R7 global enable");
        guest_ctl = gctl(2, 1, 0, 2'b01, 0) | gctl(3, 0, 0, 2'b10, 0);
        send(16'h0040, 1, 0, 0, STS0, guest_ctl, "R7 wrong type");

        // R9: guest slots 0 and 2 both match
        guest_addr[0 +: AW] = 32'h40;
        guest_ctl = gctl(0, 1, 0, 2'b10, 0) | gctl(2, 1, 0, 2'b10, 0);
        send(16'h0040, 1, 2, 0, hitsts(STS0, 0), guest_ctl, "R9 guest first match");

        // R12: top of port space
        clear_all();
        guest_addr[0 +: AW] = 32'h1_0000;
        guest_ctl = gctl(0, 1, 0, 2'b10, 0);
        send(16'hFFFF, 4, 2, 0, hitsts(STS0, 0), guest_ctl, "R12 reaches 0x10000");
        guest_addr[0 +: AW] = 32'h0;
        send(16'hFFFF, 4, 0, 0, STS0, guest_ctl, "R12 no wrap to 0");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule